// File: doc/BRIEF.md
# SPI Register Slave for a Timekeeping Peripheral

This block is the serial front end of a small real-time clock peripheral. A host opens a transaction by raising chip select, then sends an address byte and one or more data bytes. Each data byte either writes a location in a 7-bit, byte-addressed register space or reads one back. The space holds the time and alarm registers, a control byte, a status byte, the configuration byte for the battery charger, and a 96-byte scratch RAM.

The time, alarm and status registers live in neighbouring blocks. This block reaches them through a simple register port, with one-cycle read and write strobes, an address and write data. It expects the read data to be returned combinationally. The control byte, the charger byte and the RAM are stored here.

Consecutive data bytes in one transaction step through consecutive addresses. A run that passes the top of the RAM goes back to the bottom of the RAM. All serial inputs are brought into the system clock domain by synchronizers, and edges are detected there.

Top module: `spi_rtc_regif`

## Requirements
- R1: The first byte after chip select rises is the address byte, sent MSB first. Bit 7 = 1 starts a write transaction and bit 7 = 0 starts a read transaction; bits 6:0 are the start address. Data bytes sent on MOSI during a read transaction change no register.
- R2: The serial mode has SCLK idling low. MOSI is sampled on the falling SCLK edge and MISO changes on the rising edge, MSB first. Chip select is active high.
- R3: Every data byte after the first moves to the next address. A 7-byte read from 0x00 returns locations 0x00 to 0x06 in order and issues exactly one `reg_rd` strobe per data byte.
- R4: Address 0x0F holds the control byte and 0x11 holds the charger byte; both are readable and appear on `ctrl_byte` and `trickle_byte`. Address 0x10 (status) is read from the register port. Writes to 0x10 are ignored and issue no `reg_wr`.
- R5: Addresses 0x20 to 0x7F are 96 bytes of RAM that can be read and written.
- R6: While control bit 6 is 1, writes to every address other than 0x0F are ignored. A write to 0x0F is always accepted.
- R7: `spi_miso_oe` is 1 only during the data bytes of a read transaction. It is 0 during the address byte and within one clock after chip select falls.
- R8: If chip select falls in the middle of a byte, the partial byte is discarded and no write takes place.
- R9: A burst that passes address 0x7F continues at 0x20.
- R10: Addresses 0x00 to 0x0E are reached through the register port: a write gives a one-cycle `reg_wr` with `reg_addr` and `reg_wdata`. Addresses 0x12 to 0x1F read as 0x00 and ignore writes.
- R11: After reset, `ctrl_byte` = 0x00, `trickle_byte` = 0x00 and `spi_miso_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| reg_addr | output | 7 | Address of the current location |
| reg_wdata | output | 8 | Write data for the register port |
| reg_wr | output | 1 | One-cycle write strobe for time, alarm and status logic |
| reg_rd | output | 1 | One-cycle read strobe for time, alarm and status logic |
| reg_rdata | input | 8 | Read data returned combinationally by the neighbouring logic |
| ctrl_byte | output | 8 | Current control byte |
| trickle_byte | output | 8 | Current charger configuration byte |

## Verification
The embedded properties rely on three assumptions about the inputs:
- Each SCLK half period spans several system clocks, so sampling and shifting edges are never adjacent and the byte-complete pulse is isolated.
- `reg_rdata` is valid in the same cycle as `reg_rd`.
- Chip select changes only while SCLK is idle low.

The stimulus keeps within these limits. It holds each SCLK level for 13 clocks (just under 2 MHz at a 50 MHz system clock) and changes MOSI only on rising SCLK. Its register-port model answers combinationally. It raises and drops chip select only with SCLK low, including the aborted transfer that cuts a byte after five bits.

// File: rtl/spi_rtc_pkg.sv
// Package: shared types, address map constants and the address step rule
// for the timekeeping SPI register slave.
package spi_rtc_pkg;

    localparam int REG_AW = 7;   // register address width (bit 7 of the first byte is the direction)
    localparam int REG_DW = 8;   // serial word and register width

    localparam logic [REG_AW-1:0] ADR_PORT_LAST = 7'h0E; // time + alarm window ends here
    localparam logic [REG_AW-1:0] ADR_CTRL      = 7'h0F;
    localparam logic [REG_AW-1:0] ADR_STATUS    = 7'h10;
    localparam logic [REG_AW-1:0] ADR_CHARGE    = 7'h11;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } xfer_phase_t;

    // Next address in a burst: wraps from the top of RAM back to its base.
    function automatic logic [REG_AW-1:0] step_addr(
        input logic [REG_AW-1:0] cur,
        input logic [REG_AW-1:0] ram_base,
        input logic [REG_AW-1:0] ram_last
    );
        if (cur == ram_last) begin
            return ram_base;
        end
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings SCLK, chip select and MOSI into the system clock domain with
// two-flop synchronizers and flags the shifting (leading) and sampling
// (trailing) SCLK edges.
// Assumes: the system clock is several times faster than SCLK.
module spi_pin_sync #(
    parameter bit CPOL      = 1'b0,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_in,
    input  logic mosi_in,
    output logic cs_s,
    output logic mosi_s,
    output logic lead_edge,
    output logic samp_edge
);

    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_LVL = {CPOL, 2'b00};

    logic [NPIN-1:0] raw_pins;
    logic [NPIN-1:0] synced;
    logic            sclk_prev;
    logic            sclk_rise;
    logic            sclk_fall;

    assign raw_pins = {sclk_in, cs_in, mosi_in};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        logic [SYNC_DEPTH-1:0] stage;
        // Shift chain for one asynchronous pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage <= {SYNC_DEPTH{RST_LVL[g]}};
            end else begin
                stage <= {stage[SYNC_DEPTH-2:0], raw_pins[g]};
            end
        end
        assign synced[g] = stage[SYNC_DEPTH-1];
    end

    // Previous synchronized SCLK level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= CPOL;
        end else begin
            sclk_prev <= synced[2];
        end
    end

    assign sclk_rise = synced[2] & ~sclk_prev;
    assign sclk_fall = ~synced[2] & sclk_prev;
    assign cs_s      = synced[1];
    assign mosi_s    = synced[0];

    if (CPOL == 1'b0) begin : g_idle_low
        assign lead_edge = sclk_rise;
        assign samp_edge = sclk_fall;
    end else begin : g_idle_high
        assign lead_edge = sclk_fall;
        assign samp_edge = sclk_rise;
    end

    AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lead_edge |=> !lead_edge); // R2

    AST_SAMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_edge |=> !samp_edge); // R2

endmodule

// File: rtl/spi_shift_engine.sv
// Module: spi_shift_engine
// Byte-wide serial shifter. It samples MOSI on the trailing edge, shifts MISO
// out MSB first on the leading edge, and pulses byte_done once per complete
// byte. Dropping `active` clears all partial state.
// Assumes: load_en comes only with a leading edge at bit index 0.
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  lead_edge,
    input  logic                  samp_edge,
    input  logic                  mosi_s,
    input  logic                  load_en,
    input  logic [W-1:0]          load_byte,
    output logic                  byte_done,
    output logic [W-1:0]          rx_byte,
    output logic [$clog2(W)-1:0]  bit_idx,
    output logic                  miso_bit
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic [CW-1:0] bit_q;
    logic [W-1:0]  rx_q;
    logic [W-1:0]  tx_q;
    logic          done_q;
    logic          miso_q;

    // Receive side: count sampled bits and flag a full byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_q  <= '0;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (samp_edge) begin
                rx_q <= {rx_q[W-2:0], mosi_s};
                if (bit_q == LAST_BIT) begin
                    bit_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // Transmit side: load a fresh byte or shift the held one on the leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (lead_edge) begin
            if (load_en) begin
                miso_q <= load_byte[W-1];
                tx_q   <= {load_byte[W-2:0], 1'b0};
            end else begin
                miso_q <= tx_q[W-1];
                tx_q   <= {tx_q[W-2:0], 1'b0};
            end
        end
    end

    assign byte_done = done_q;
    assign rx_byte   = rx_q;
    assign bit_idx   = bit_q;
    assign miso_bit  = miso_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R2

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_idx == '0 && !byte_done)); // R8

endmodule

// File: rtl/spi_reg_space.sv
// Module: spi_reg_space
// Register space behind the serial engine. It stores the control byte, the
// charger byte and the RAM, applies write protection, routes time, alarm and
// status accesses to the register port, and builds the read data.
// Assumes: ext_rdata is valid in the same cycle as ext_rd.
module spi_reg_space
    import spi_rtc_pkg::*;
#(
    parameter logic [REG_AW-1:0] RAM_BASE  = 7'h20,
    parameter int                RAM_DEPTH = 96,
    parameter int                WP_BIT    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              rd_en,
    output logic [REG_DW-1:0] rd_data,
    output logic              ext_wr,
    output logic              ext_rd,
    input  logic [REG_DW-1:0] ext_rdata,
    output logic [REG_DW-1:0] ctrl_q,
    output logic [REG_DW-1:0] trickle_q
);

    localparam int IW = $clog2(RAM_DEPTH);
    localparam logic [REG_AW-1:0] RAM_LAST = RAM_BASE + REG_AW'(RAM_DEPTH - 1);

    logic              is_port;
    logic              is_ram;
    logic              wp_on;
    logic              wr_ok;
    logic [IW-1:0]     ram_off;
    logic [REG_DW-1:0] ram_mem [RAM_DEPTH];

    assign is_port = (addr <= ADR_PORT_LAST);
    assign is_ram  = (addr >= RAM_BASE) && (addr <= RAM_LAST);
    assign wp_on   = ctrl_q[WP_BIT];
    assign wr_ok   = wr_en && ((addr == ADR_CTRL) || !wp_on);
    assign ram_off = IW'(addr - RAM_BASE);
    assign ext_wr  = wr_ok && is_port;
    assign ext_rd  = rd_en && (is_port || (addr == ADR_STATUS));

    // Locally held configuration bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            trickle_q <= '0;
        end else begin
            if (wr_en && addr == ADR_CTRL) begin
                ctrl_q <= wr_data;
            end
            if (wr_ok && addr == ADR_CHARGE) begin
                trickle_q <= wr_data;
            end
        end
    end

    // RAM write port; the RAM contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_ok && is_ram) begin
            ram_mem[ram_off] <= wr_data;
        end
    end

    // Read data selection by address region.
    always_comb begin
        rd_data = '0;
        if (is_port || addr == ADR_STATUS) begin
            rd_data = ext_rdata;
        end else if (addr == ADR_CTRL) begin
            rd_data = ctrl_q;
        end else if (addr == ADR_CHARGE) begin
            rd_data = trickle_q;
        end else if (is_ram) begin
            rd_data = ram_mem[ram_off];
        end
    end

    AST_CTRL_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CTRL) |=> ctrl_q == $past(wr_data)); // R6

    AST_WP_HOLDS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp_on && addr == ADR_CHARGE) |=> $stable(trickle_q)); // R6

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_wr && ext_rd)); // R10

endmodule

// File: rtl/spi_rtc_regif.sv
// Module: spi_rtc_regif (top)
// Serial register slave for a timekeeping peripheral. It decodes the address
// byte and runs burst reads or writes over the register space. The time,
// alarm and status registers are reached through the register port.
// Assumes: SCLK idles low outside transactions, and chip select changes only
// while SCLK is idle.
module spi_rtc_regif
    import spi_rtc_pkg::*;
#(
    parameter logic [REG_AW-1:0] RAM_BASE  = 7'h20,
    parameter int                RAM_DEPTH = 96,
    parameter int                WP_BIT    = 6,
    parameter bit                CPOL      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [REG_DW-1:0] reg_rdata,
    output logic [REG_DW-1:0] ctrl_byte,
    output logic [REG_DW-1:0] trickle_byte
);

    localparam int BW = $clog2(REG_DW);
    localparam logic [REG_AW-1:0] RAM_LAST = RAM_BASE + REG_AW'(RAM_DEPTH - 1);

    logic              cs_s;
    logic              mosi_s;
    logic              lead_edge;
    logic              samp_edge;
    logic              byte_done;
    logic [REG_DW-1:0] rx_byte;
    logic [BW-1:0]     bit_idx;
    logic              miso_bit;
    logic              fetch;
    logic              wr_en;
    logic [REG_DW-1:0] rd_data;
    xfer_phase_t       phase_q;
    logic [REG_AW-1:0] addr_q;
    logic              oe_q;

    spi_pin_sync #(.CPOL(CPOL), .SYNC_DEPTH(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_in     (spi_cs),
        .mosi_in   (spi_mosi),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .lead_edge (lead_edge),
        .samp_edge (samp_edge)
    );

    assign fetch = cs_s && lead_edge && (bit_idx == '0) && (phase_q == PH_READ);
    assign wr_en = byte_done && (phase_q == PH_WRITE);

    spi_shift_engine #(.W(REG_DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (cs_s),
        .lead_edge (lead_edge),
        .samp_edge (samp_edge),
        .mosi_s    (mosi_s),
        .load_en   (fetch),
        .load_byte (rd_data),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .bit_idx   (bit_idx),
        .miso_bit  (miso_bit)
    );

    spi_reg_space #(
        .RAM_BASE  (RAM_BASE),
        .RAM_DEPTH (RAM_DEPTH),
        .WP_BIT    (WP_BIT)
    ) u_space (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr_q),
        .wr_en     (wr_en),
        .wr_data   (rx_byte),
        .rd_en     (fetch),
        .rd_data   (rd_data),
        .ext_wr    (reg_wr),
        .ext_rd    (reg_rd),
        .ext_rdata (reg_rdata),
        .ctrl_q    (ctrl_byte),
        .trickle_q (trickle_byte)
    );

    // Transaction sequencer: decodes the address byte, then steps the address per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ADDR;
            addr_q  <= '0;
            oe_q    <= 1'b0;
        end else begin
            oe_q <= cs_s && (phase_q == PH_READ);
            if (!cs_s) begin
                phase_q <= PH_ADDR;
            end else if (byte_done) begin
                if (phase_q == PH_ADDR) begin
                    addr_q  <= rx_byte[REG_AW-1:0];
                    phase_q <= rx_byte[REG_DW-1] ? PH_WRITE : PH_READ;
                end else begin
                    addr_q <= step_addr(addr_q, RAM_BASE, RAM_LAST);
                end
            end
        end
    end

    assign spi_miso    = miso_bit;
    assign spi_miso_oe = oe_q;
    assign reg_addr    = addr_q;
    assign reg_wdata   = rx_byte;

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && byte_done && phase_q != PH_ADDR && addr_q == RAM_LAST)
        |=> addr_q == RAM_BASE); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && byte_done && phase_q != PH_ADDR && addr_q != RAM_LAST)
        |=> addr_q == REG_AW'($past(addr_q) + 1'b1)); // R3

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !spi_miso_oe); // R7

    AST_RD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> phase_q == PH_READ); // R1

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R10

endmodule

// File: tb/tb_spi_rtc_regif.sv
// Bench for spi_rtc_regif: a vector table walk, then directed corner cases.
module tb_spi_rtc_regif;

    localparam int HALF = 13;  // system clocks per SCLK level (~1.92 MHz)
    localparam int NVEC = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_rdata;
    logic [7:0] ctrl_byte;
    logic [7:0] trickle_byte;

    logic [7:0] ext_regs [16];
    logic [7:0] status_val = 8'hC3;
    int         ext_wr_cnt;
    int         ext_rd_cnt;
    int         n_checks = 0;
    int         n_err = 0;

    always #10 clk = ~clk;

    spi_rtc_regif dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (sclk),
        .spi_cs       (cs),
        .spi_mosi     (mosi),
        .spi_miso     (miso),
        .spi_miso_oe  (miso_oe),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .ctrl_byte    (ctrl_byte),
        .trickle_byte (trickle_byte)
    );

    // Model of the time/alarm/status logic on the register port.
    assign reg_rdata = (reg_addr <= 7'h0E) ? ext_regs[reg_addr[3:0]] :
                       (reg_addr == 7'h10) ? status_val : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) ext_regs[i] <= 8'(8'h10 + i);
            ext_wr_cnt <= 0;
            ext_rd_cnt <= 0;
        end else begin
            if (reg_wr) begin
                ext_regs[reg_addr[3:0]] <= reg_wdata;
                ext_wr_cnt <= ext_wr_cnt + 1;
            end
            if (reg_rd) ext_rd_cnt <= ext_rd_cnt + 1;
        end
    end

    // {write, addr[6:0], data, expected}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 7'h20, 8'hA5, 8'h00},   // R5 RAM low end
        {1'b0, 7'h20, 8'h00, 8'hA5},
        {1'b1, 7'h7F, 8'h3C, 8'h00},   // R5 RAM top
        {1'b0, 7'h7F, 8'h00, 8'h3C},
        {1'b1, 7'h11, 8'h5A, 8'h00},   // R4 charger byte
        {1'b0, 7'h11, 8'h00, 8'h5A},
        {1'b1, 7'h03, 8'h77, 8'h00},   // R10 register port
        {1'b0, 7'h03, 8'h00, 8'h77},
        {1'b0, 7'h15, 8'h00, 8'h00},   // R10 hole reads zero
        {1'b1, 7'h15, 8'hEE, 8'h00},
        {1'b0, 7'h15, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sclk = 1'b1;
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b0;
            wait_clk(HALF);
        end
    endtask

    task automatic select_dev();
        @(negedge clk);
        cs = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic release_dev();
        @(negedge clk);
        cs = 1'b0;
        mosi = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic write1(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rx;
        select_dev();
        xfer_bits({1'b1, a}, 8, rx);
        xfer_bits(d, 8, rx);
        release_dev();
    endtask

    task automatic read1(input logic [6:0] a, output logic [7:0] d);
        logic [7:0] rx;
        select_dev();
        xfer_bits({1'b0, a}, 8, rx);
        xfer_bits(8'hFF, 8, d);
        release_dev();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic [7:0] rx;
        int         base_cnt;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R11 reset state
        check("R11 oe", {31'd0, miso_oe}, 32'd0);
        check("R11 ctrl", {24'd0, ctrl_byte}, 32'h00);
        check("R11 trickle", {24'd0, trickle_byte}, 32'h00);

        // Table walk (R4 R5 R10)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][23]) begin
                write1(VEC[i][22:16], VEC[i][15:8]);
            end else begin
                read1(VEC[i][22:16], rd);
                check($sformatf("vector %0d (R4 R5 R10 R2)", i), {24'd0, rd}, {24'd0, VEC[i][7:0]});
            end
        end
        check("R4 trickle port", {24'd0, trickle_byte}, 32'h5A);

        // R3 burst read of time registers, one strobe per byte
        base_cnt = ext_rd_cnt;
        select_dev();
        xfer_bits(8'h00, 8, rx);
        for (int i = 0; i < 7; i++) begin
            xfer_bits(8'h00, 8, rd);
            check($sformatf("R3 burst byte %0d", i), {24'd0, rd},
                  (i == 3) ? 32'h77 : 32'(8'h10 + i));
        end
        release_dev();
        check("R3 read strobes", 32'(ext_rd_cnt - base_cnt), 32'd7);

        // R7 drive enable around a read
        select_dev();
        check("R7 oe during address", {31'd0, miso_oe}, 32'd0);
        xfer_bits(8'h20, 8, rx);
        check("R7 oe in data phase", {31'd0, miso_oe}, 32'd1);
        xfer_bits(8'h00, 8, rd);
        release_dev();
        check("R7 oe after release", {31'd0, miso_oe}, 32'd0);

        // R1 MOSI bytes during a read write nothing
        select_dev();
        xfer_bits(8'h20, 8, rx);
        xfer_bits(8'h5F, 8, rd);
        xfer_bits(8'hC4, 8, rd);
        release_dev();
        read1(7'h20, rd);
        check("R1 read leaves RAM", {24'd0, rd}, 32'hA5);

        // R9 burst write across the RAM top
        select_dev();
        xfer_bits(8'hFE, 8, rx);
        xfer_bits(8'h01, 8, rx);
        xfer_bits(8'h02, 8, rx);
        xfer_bits(8'h03, 8, rx);
        release_dev();
        read1(7'h20, rd);
        check("R9 wrapped write", {24'd0, rd}, 32'h03);
        select_dev();
        xfer_bits(8'h7F, 8, rx);
        xfer_bits(8'h00, 8, rd);
        check("R9 read at top", {24'd0, rd}, 32'h02);
        xfer_bits(8'h00, 8, rd);
        check("R9 read after wrap", {24'd0, rd}, 32'h03);
        release_dev();

        // R4 status reads from the port, writes ignored
        base_cnt = ext_wr_cnt;
        write1(7'h10, 8'h00);
        check("R4 status write no strobe", 32'(ext_wr_cnt - base_cnt), 32'd0);
        read1(7'h10, rd);
        check("R4 status read", {24'd0, rd}, 32'hC3);

        // R6 write protection
        write1(7'h30, 8'h99);
        write1(7'h0F, 8'h40);
        check("R6 ctrl set", {24'd0, ctrl_byte}, 32'h40);
        base_cnt = ext_wr_cnt;
        write1(7'h30, 8'h11);
        write1(7'h05, 8'hAB);
        write1(7'h11, 8'hFF);
        check("R6 port write blocked", 32'(ext_wr_cnt - base_cnt), 32'd0);
        check("R6 charger blocked", {24'd0, trickle_byte}, 32'h5A);
        read1(7'h30, rd);
        check("R6 RAM blocked", {24'd0, rd}, 32'h99);
        write1(7'h0F, 8'h04);
        check("R6 ctrl write under protect", {24'd0, ctrl_byte}, 32'h04);
        write1(7'h30, 8'h11);
        read1(7'h30, rd);
        check("R6 RAM after unprotect", {24'd0, rd}, 32'h11);

        // R8 aborted byte
        write1(7'h21, 8'h66);
        select_dev();
        xfer_bits(8'hA1, 8, rx);
        xfer_bits(8'h55, 5, rx);
        release_dev();
        read1(7'h21, rd);
        check("R8 partial byte dropped", {24'd0, rd}, 32'h66);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule